// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is a single comparator channel of an event timer. It watches a shared 32-bit free-running main count and, on every tick strobe while the count is running, compares it for equality with its own comparator value. On a match the channel raises an interrupt in one of three forms, chosen by its configuration: a level line held high until cleared, a one-cycle edge pulse on a selected interrupt pin, or a request for a message write that carries an address and data word.

In periodic mode the channel reloads its comparator by adding a period value after each match. Whenever it is rescheduled while the count has already passed the comparator, it rounds the comparator up to the next multiple of the period ahead of the count. The channel checks interrupt pin selections against a read-only mask of allowed pins. It drops an asserted level interrupt whenever a configuration change would otherwise leave it stuck. If the main count is stopped after an armed match time has passed without being seen, the channel delivers that interrupt at the moment of stopping. The interrupt controller and the message fabric sit outside; this block only presents the pin number, level, pulse and message-request outputs.

Top module: `evt_timer_channel`

## Requirements
- R1: After reset the configuration reads {ALLOW_PINS, 32'h0000_8010}, with the periodic-capable bit 4 and the message-capable bit 15 set. The comparator reads 32'hFFFF_FFFF, the period and route read 0, and level_o, pulse_o, msg_req_o and pin_o are 0.
- R2: A configuration write (wr_sel_i = 0) merges wr_data_i under wr_mask_i into the writable bits only: bit 1 level type, bit 2 interrupt enable, bit 3 periodic, bit 6 value-set, bits 13:9 pin, bit 14 message enable. The allowed-pin mask in bits 63:32 and capability bits 4, 5 and 15 keep their value. The 32-bit-mode bit 8 and all other bits read 0.
- R3: A configuration write that selects a nonzero pin p with bit p of the allowed-pin mask clear leaves the pin field 0. An allowed pin is kept, and pin_o shows it unless message mode is active.
- R4: In periodic mode a comparator write (wr_sel_i = 1, low 32 bits) always sets the period. It sets the comparator to the same value only when the value-set bit is 1. Every comparator write clears the value-set bit.
- R5: In one-shot mode a comparator write changes only the comparator. One clock after the configuration shows one-shot mode, the period reads 0.
- R6: A match is tick_i high with run_i high and count_i equal to the comparator. A periodic match advances the comparator by the period at the same clock edge that registers the interrupt.
- R7: When a periodic channel with a nonzero period is rescheduled, the comparator becomes cmp + ((count − cmp)/period + 1)·period if the count is at or past it (count − cmp modulo 2^32 below 2^31). Rescheduling happens on a rising run_i, or on a comparator write that changes the comparator or period while running.
- R8: A match with the interrupt-enable bit 0 produces no level, pulse or message. A match while the level status is already set does not signal again.
- R9: Message mode is active when bits 14 and 15 are both 1. A match then pulses msg_req_o for one cycle, with msg_addr_o taken from route bits 63:32 and msg_data_o from route bits 31:0 (route written with wr_sel_i = 2). No pin signal is raised, and pin_o reads 0.
- R10: Outside message mode, a match with a nonzero pin gives a one-cycle pulse_o if bit 1 is 0 (edge type). If bit 1 is 1 (level type), it sets level_o until cleared.
- R11: An asserted level is cleared by sts_clr_i. It is also cleared by a configuration write that leaves the interrupt disabled, edge type or message mode active, or that changes the pin number.
- R12: When run_i falls while the channel is armed and the count is strictly past the comparator (count − cmp nonzero and below 2^31), the interrupt is delivered at that clock. The channel is armed by a comparator-changing write while running or by run_i rising. A one-shot match disarms it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Main count is running |
| tick_i | input | 1 | Count advance strobe; compare is evaluated on it |
| count_i | input | 32 | Shared main count value |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 configuration, 1 comparator, 2 route |
| wr_data_i | input | 64 | Write data |
| wr_mask_i | input | 64 | Per-bit write mask |
| sts_clr_i | input | 1 | Clear the level status |
| cfg_o | output | 64 | Configuration and capability register |
| cmp_o | output | 32 | Comparator value |
| period_o | output | 32 | Period value |
| route_o | output | 64 | Message route register |
| pin_o | output | 5 | Effective interrupt pin, 0 when unconnected |
| level_o | output | 1 | Level interrupt line |
| pulse_o | output | 1 | Edge interrupt pulse |
| msg_req_o | output | 1 | Message write request |
| msg_addr_o | output | 32 | Message address |
| msg_data_o | output | 32 | Message data |

## Verification
A wrong comparator or period shows up as a missing or misplaced interrupt on the tick whose count equals the expected comparator, and directly on cmp_o one clock after the write, reload or run edge that set it. A stale level status appears as level_o held high after the configuration write or clear that should have dropped it, visible the next clock. An armed flag left in the wrong state only shows when run_i falls, as a missing or extra pulse in that clock.

// File: rtl/evtc_pkg.sv
package evtc_pkg;

    localparam int CNT_W = 32;
    localparam int PIN_W = 5;
    localparam int CFG_W = 2 * CNT_W;

    // configuration bit positions
    localparam int B_LVL   = 1;
    localparam int B_IEN   = 2;
    localparam int B_PER   = 3;
    localparam int B_PCAP  = 4;
    localparam int B_VSET  = 6;
    localparam int B_PIN_L = 9;
    localparam int B_PIN_H = B_PIN_L + PIN_W - 1;
    localparam int B_MEN   = 14;
    localparam int B_MCAP  = 15;

    localparam logic [CFG_W-1:0] PIN_FIELD =
        ((CFG_W'(1) << PIN_W) - CFG_W'(1)) << B_PIN_L;
    localparam logic [CFG_W-1:0] WR_MASK =
        (CFG_W'(1) << B_LVL) | (CFG_W'(1) << B_IEN) | (CFG_W'(1) << B_PER) |
        (CFG_W'(1) << B_VSET) | (CFG_W'(1) << B_MEN) | PIN_FIELD;
    localparam logic [CFG_W-1:0] RO_MASK =
        {{CNT_W{1'b1}}, {CNT_W{1'b0}}} | (CFG_W'(1) << B_PCAP) | (CFG_W'(1) << B_MCAP);
    localparam logic [CFG_W-1:0] CAP_RESET =
        (CFG_W'(1) << B_PCAP) | (CFG_W'(1) << B_MCAP);

    typedef enum logic [1:0] {
        SEL_CFG   = 2'd0,
        SEL_CMP   = 2'd1,
        SEL_ROUTE = 2'd2,
        SEL_NONE  = 2'd3
    } wr_sel_e;

    typedef struct packed {
        logic [CNT_W-1:0] cmp;
        logic [CNT_W-1:0] per;
        logic             run;
        logic             armed;
    } cmp_state_t;

    typedef struct packed {
        logic [CFG_W-1:0] route;
        logic             sts;
        logic             pulse;
        logic             msg;
        logic [CNT_W-1:0] maddr;
        logic [CNT_W-1:0] mdata;
    } irq_state_t;

endpackage

// File: rtl/evtc_cfg_unit.sv
module evtc_cfg_unit
    import evtc_pkg::*;
#(
    parameter logic [CNT_W-1:0] ALLOW_PINS = 32'h00F0_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_cfg_i,
    input  logic             wr_cmp_i,
    input  logic [CFG_W-1:0] wr_data_i,
    input  logic [CFG_W-1:0] wr_mask_i,
    output logic [CFG_W-1:0] cfg_q_o,
    output logic             drop_lvl_o
);

    localparam logic [CFG_W-1:0] CFG_RESET = {ALLOW_PINS, {CNT_W{1'b0}}} | CAP_RESET;

    logic [CFG_W-1:0] cfg_q, cfg_d;
    logic [CFG_W-1:0] merged, cand;
    logic [CNT_W-1:0] allow;
    logic [PIN_W-1:0] new_pin, old_pin;
    logic             new_msg;

    always_comb begin
        cfg_d      = cfg_q;
        drop_lvl_o = 1'b0;
        merged     = (cfg_q & ~wr_mask_i) | (wr_data_i & wr_mask_i);
        cand       = (merged & WR_MASK) | (cfg_q & RO_MASK);
        allow      = cand[CFG_W-1:CNT_W];
        new_pin    = cand[B_PIN_H:B_PIN_L];
        old_pin    = cfg_q[B_PIN_H:B_PIN_L];
        if (new_pin != '0 && !allow[new_pin]) begin
            cand[B_PIN_H:B_PIN_L] = '0;
            new_pin               = '0;
        end
        new_msg = cand[B_MEN] & cand[B_MCAP];
        if (wr_cfg_i && cand != cfg_q) begin
            cfg_d      = cand;
            drop_lvl_o = !cand[B_IEN] || !cand[B_LVL] || new_msg || (new_pin != old_pin);
        end
        if (wr_cmp_i) begin
            cfg_d[B_VSET] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_RESET;
        else        cfg_q <= cfg_d;
    end

    assign cfg_q_o = cfg_q;

endmodule

// File: rtl/evtc_catchup.sv
module evtc_catchup
    import evtc_pkg::*;
(
    input  logic [CNT_W-1:0] cmp_i,
    input  logic [CNT_W-1:0] per_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [CNT_W-1:0] next_o,
    output logic             reached_o,
    output logic             beyond_o
);

    logic [CNT_W-1:0] diff, divisor, quo, steps;

    always_comb begin
        diff      = cnt_i - cmp_i;
        reached_o = !diff[CNT_W-1];
        beyond_o  = reached_o && (diff != '0);
        divisor   = (per_i == '0) ? CNT_W'(1) : per_i;
        quo       = diff / divisor;
        steps     = (quo + CNT_W'(1)) * per_i;
        next_o    = cmp_i + steps;
    end

endmodule

// File: rtl/evtc_cmp_unit.sv
module evtc_cmp_unit
    import evtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             periodic_i,
    input  logic             vset_i,
    input  logic             wr_cmp_i,
    input  logic [CNT_W-1:0] wr_data_i,
    input  logic [CNT_W-1:0] wr_mask_i,
    input  logic             tick_i,
    input  logic             run_i,
    input  logic [CNT_W-1:0] count_i,
    output logic [CNT_W-1:0] cmp_o,
    output logic [CNT_W-1:0] per_o,
    output logic             fire_o
);

    cmp_state_t       q, d;
    logic [CNT_W-1:0] wr_cmp, wr_per;
    logic [CNT_W-1:0] cu_cmp, cu_per, cu_next;
    logic             cu_reached, cu_beyond;
    logic [CNT_W-1:0] now_next;
    logic             now_reached, now_beyond;
    logic             match, late, resched;

    // catch-up on the value being scheduled
    evtc_catchup u_catch_new (
        .cmp_i     (cu_cmp),
        .per_i     (cu_per),
        .cnt_i     (count_i),
        .next_o    (cu_next),
        .reached_o (cu_reached),
        .beyond_o  (cu_beyond)
    );

    // position of the held comparator against the count, for stop delivery
    evtc_catchup u_catch_cur (
        .cmp_i     (q.cmp),
        .per_i     (q.per),
        .cnt_i     (count_i),
        .next_o    (now_next),
        .reached_o (now_reached),
        .beyond_o  (now_beyond)
    );

    always_comb begin
        d       = q;
        d.run   = run_i;
        resched = 1'b0;
        wr_per  = (q.per & ~wr_mask_i) | (wr_data_i & wr_mask_i);
        wr_cmp  = (q.cmp & ~wr_mask_i) | (wr_data_i & wr_mask_i);
        match   = tick_i && run_i && (count_i == q.cmp);
        late    = q.run && !run_i && q.armed && now_beyond;

        if (wr_cmp_i) begin
            if (periodic_i) begin
                d.per = wr_per;
                d.cmp = vset_i ? wr_per : q.cmp;
            end else begin
                d.cmp = wr_cmp;
            end
            if ((d.cmp != q.cmp || d.per != q.per) && run_i) begin
                resched = 1'b1;
                d.armed = 1'b1;
            end
        end else if (match) begin
            if (periodic_i) d.cmp = q.cmp + q.per;
            else            d.armed = 1'b0;
        end

        if (!q.run && run_i) begin
            resched = 1'b1;
            d.armed = 1'b1;
        end

        if (late) begin
            d.armed = 1'b0;
        end

        cu_cmp = d.cmp;
        cu_per = d.per;
        if (resched && periodic_i && d.per != '0 && cu_reached) begin
            d.cmp = cu_next;
        end

        if (!periodic_i) begin
            d.per = '0;
        end

        fire_o = match || late;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cmp   <= '1;
            q.per   <= '0;
            q.run   <= 1'b0;
            q.armed <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign cmp_o = q.cmp;
    assign per_o = q.per;

endmodule

// File: rtl/evtc_irq_unit.sv
module evtc_irq_unit
    import evtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire_i,
    input  logic             ien_i,
    input  logic             lvl_type_i,
    input  logic             msg_mode_i,
    input  logic [PIN_W-1:0] pin_i,
    input  logic             drop_lvl_i,
    input  logic             sts_clr_i,
    input  logic             wr_route_i,
    input  logic [CFG_W-1:0] wr_data_i,
    input  logic [CFG_W-1:0] wr_mask_i,
    output logic [CFG_W-1:0] route_o,
    output logic             level_o,
    output logic             pulse_o,
    output logic             msg_req_o,
    output logic [CNT_W-1:0] msg_addr_o,
    output logic [CNT_W-1:0] msg_data_o
);

    irq_state_t q, d;

    always_comb begin
        d       = q;
        d.pulse = 1'b0;
        d.msg   = 1'b0;
        if (wr_route_i) begin
            d.route = (q.route & ~wr_mask_i) | (wr_data_i & wr_mask_i);
        end
        if (sts_clr_i || drop_lvl_i) begin
            d.sts = 1'b0;
        end
        if (fire_i && ien_i && !q.sts) begin
            if (msg_mode_i) begin
                d.msg   = 1'b1;
                d.maddr = q.route[CFG_W-1:CNT_W];
                d.mdata = q.route[CNT_W-1:0];
            end else if (pin_i != '0) begin
                if (lvl_type_i) d.sts   = 1'b1;
                else            d.pulse = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign route_o    = q.route;
    assign level_o    = q.sts;
    assign pulse_o    = q.pulse;
    assign msg_req_o  = q.msg;
    assign msg_addr_o = q.maddr;
    assign msg_data_o = q.mdata;

endmodule

// File: rtl/evt_timer_channel.sv
module evt_timer_channel
    import evtc_pkg::*;
#(
    parameter logic [CNT_W-1:0] ALLOW_PINS = 32'h00F0_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_sel_i,
    input  logic [CFG_W-1:0] wr_data_i,
    input  logic [CFG_W-1:0] wr_mask_i,
    input  logic             sts_clr_i,
    output logic [CFG_W-1:0] cfg_o,
    output logic [CNT_W-1:0] cmp_o,
    output logic [CNT_W-1:0] period_o,
    output logic [CFG_W-1:0] route_o,
    output logic [PIN_W-1:0] pin_o,
    output logic             level_o,
    output logic             pulse_o,
    output logic             msg_req_o,
    output logic [CNT_W-1:0] msg_addr_o,
    output logic [CNT_W-1:0] msg_data_o
);

    logic             wr_cfg, wr_cmp, wr_route;
    logic [CFG_W-1:0] cfg_q;
    logic             drop_lvl, fire, msg_mode;

    assign wr_cfg   = wr_en_i && (wr_sel_i == SEL_CFG);
    assign wr_cmp   = wr_en_i && (wr_sel_i == SEL_CMP);
    assign wr_route = wr_en_i && (wr_sel_i == SEL_ROUTE);

    evtc_cfg_unit #(.ALLOW_PINS(ALLOW_PINS)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_cfg_i   (wr_cfg),
        .wr_cmp_i   (wr_cmp),
        .wr_data_i  (wr_data_i),
        .wr_mask_i  (wr_mask_i),
        .cfg_q_o    (cfg_q),
        .drop_lvl_o (drop_lvl)
    );

    evtc_cmp_unit u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .periodic_i (cfg_q[B_PER]),
        .vset_i     (cfg_q[B_VSET]),
        .wr_cmp_i   (wr_cmp),
        .wr_data_i  (wr_data_i[CNT_W-1:0]),
        .wr_mask_i  (wr_mask_i[CNT_W-1:0]),
        .tick_i     (tick_i),
        .run_i      (run_i),
        .count_i    (count_i),
        .cmp_o      (cmp_o),
        .per_o      (period_o),
        .fire_o     (fire)
    );

    assign msg_mode = cfg_q[B_MEN] & cfg_q[B_MCAP];

    evtc_irq_unit u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire_i     (fire),
        .ien_i      (cfg_q[B_IEN]),
        .lvl_type_i (cfg_q[B_LVL]),
        .msg_mode_i (msg_mode),
        .pin_i      (cfg_q[B_PIN_H:B_PIN_L]),
        .drop_lvl_i (drop_lvl),
        .sts_clr_i  (sts_clr_i),
        .wr_route_i (wr_route),
        .wr_data_i  (wr_data_i),
        .wr_mask_i  (wr_mask_i),
        .route_o    (route_o),
        .level_o    (level_o),
        .pulse_o    (pulse_o),
        .msg_req_o  (msg_req_o),
        .msg_addr_o (msg_addr_o),
        .msg_data_o (msg_data_o)
    );

    assign cfg_o = cfg_q;
    assign pin_o = msg_mode ? '0 : cfg_q[B_PIN_H:B_PIN_L];

endmodule

// File: rtl/evtc_checker.sv
module evtc_checker
    import evtc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en_i,
    input logic [1:0]       wr_sel_i,
    input logic [CFG_W-1:0] cfg_o,
    input logic [CNT_W-1:0] period_o,
    input logic [PIN_W-1:0] pin_o,
    input logic             level_o,
    input logic             pulse_o
);

    // R2: allowed-pin mask is never changed by writes
    p_mask_ro_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(cfg_o[CFG_W-1:CNT_W]));

    // R4: any comparator write leaves value-set clear
    p_vset_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i == SEL_CMP) |=> !cfg_o[B_VSET]);

    // R5: one-shot configuration forces the period to zero next clock
    p_period_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_o[B_PER] |=> (period_o == '0));

    // R8: an edge pulse only follows an enabled interrupt
    p_pulse_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> $past(cfg_o[B_IEN]));

    // R11: a held level always has a connected pin
    p_level_pin_r11: assert property (@(posedge clk) disable iff (!rst_n)
        level_o |-> (pin_o != '0));

endmodule

bind evt_timer_channel evtc_checker u_evtc_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (wr_en_i),
    .wr_sel_i (wr_sel_i),
    .cfg_o    (cfg_o),
    .period_o (period_o),
    .pin_o    (pin_o),
    .level_o  (level_o),
    .pulse_o  (pulse_o)
);

// File: tb/tb_evt_timer_channel.sv
module tb_evt_timer_channel;

    localparam int CLK_PERIOD = 10;

    typedef enum int {O_CFG, O_CMP, O_PER, O_ROUTE, O_PIN, O_LVL, O_PULSE,
                      O_MSG, O_MADDR, O_MDATA} out_e;

    typedef struct {
        string       tag;
        out_e        sel;
        logic [63:0] exp;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_i = 1'b0;
    logic        tick_i = 1'b0;
    logic [31:0] count_i = '0;
    logic        wr_en_i = 1'b0;
    logic [1:0]  wr_sel_i = 2'd3;
    logic [63:0] wr_data_i = '0;
    logic [63:0] wr_mask_i = '0;
    logic        sts_clr_i = 1'b0;
    logic [63:0] cfg_o, route_o;
    logic [31:0] cmp_o, period_o, msg_addr_o, msg_data_o;
    logic [4:0]  pin_o;
    logic        level_o, pulse_o, msg_req_o;

    item_t q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;

    evt_timer_channel dut (
        .clk(clk), .rst_n(rst_n), .run_i(run_i), .tick_i(tick_i), .count_i(count_i),
        .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
        .wr_mask_i(wr_mask_i), .sts_clr_i(sts_clr_i), .cfg_o(cfg_o), .cmp_o(cmp_o),
        .period_o(period_o), .route_o(route_o), .pin_o(pin_o), .level_o(level_o),
        .pulse_o(pulse_o), .msg_req_o(msg_req_o), .msg_addr_o(msg_addr_o),
        .msg_data_o(msg_data_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [63:0] observe(out_e s);
        case (s)
            O_CFG:   return cfg_o;
            O_CMP:   return 64'(cmp_o);
            O_PER:   return 64'(period_o);
            O_ROUTE: return route_o;
            O_PIN:   return 64'(pin_o);
            O_LVL:   return 64'(level_o);
            O_PULSE: return 64'(pulse_o);
            O_MSG:   return 64'(msg_req_o);
            O_MADDR: return 64'(msg_addr_o);
            default: return 64'(msg_data_o);
        endcase
    endfunction

    // monitor: compares queued expectations away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                item_t it;
                logic [63:0] act;
                it  = q.pop_front();
                act = observe(it.sel);
                n_cmp++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s %s: actual %h expected %h", it.tag, it.sel.name(), act, it.exp);
                end
            end
        end
    end

    task automatic expect_out(string tag, out_e sel, logic [63:0] exp);
        item_t it;
        it.tag = tag; it.sel = sel; it.exp = exp;
        q.push_back(it);
    endtask

    task automatic strobes_off();
        tick_i = 1'b0; wr_en_i = 1'b0; wr_sel_i = 2'd3; sts_clr_i = 1'b0;
    endtask

    task automatic cyc(logic tk, logic [31:0] cnt, logic run);
        @(negedge clk);
        strobes_off();
        tick_i = tk; count_i = cnt; run_i = run;
        @(posedge clk); #1;
    endtask

    task automatic wr(logic [1:0] sel, logic [63:0] data, logic [63:0] mask);
        @(negedge clk);
        strobes_off();
        wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data; wr_mask_i = mask;
        @(posedge clk); #1;
    endtask

    task automatic clr_sts();
        @(negedge clk);
        strobes_off();
        sts_clr_i = 1'b1;
        @(posedge clk); #1;
    endtask

    localparam logic [63:0] ALL = '1;
    localparam logic [63:0] HI  = 64'h00F0_0000_0000_0000;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;
        // R1 reset state
        expect_out("R1", O_CFG, HI | 64'h8010);
        expect_out("R1", O_CMP, 64'hFFFF_FFFF);
        expect_out("R1", O_PER, 64'h0);
        expect_out("R1", O_LVL, 64'h0);
        expect_out("R1", O_MSG, 64'h0);
        expect_out("R1", O_PIN, 64'h0);

        // R2 / R3: all-ones write; pin 31 is outside the mask
        wr(2'd0, ALL, ALL);
        expect_out("R2", O_CFG, HI | 64'hC05E);

        // R3: pin 21 allowed, edge, enabled, one-shot
        wr(2'd0, 64'h2A04, ALL);
        expect_out("R3", O_CFG, HI | 64'hAA14);
        expect_out("R3", O_PIN, 64'd21);

        // R5: one-shot comparator write
        cyc(1'b0, 32'd0, 1'b1);
        wr(2'd1, 64'd100, ALL);
        expect_out("R5", O_CMP, 64'd100);
        expect_out("R5", O_PER, 64'd0);

        // R6 / R10 edge pulse
        cyc(1'b1, 32'd99, 1'b1);
        expect_out("R6", O_PULSE, 64'd0);
        cyc(1'b1, 32'd100, 1'b1);
        expect_out("R10", O_PULSE, 64'd1);
        cyc(1'b0, 32'd100, 1'b1);
        expect_out("R10", O_PULSE, 64'd0);

        // R10 level, R11 clear input
        wr(2'd0, 64'h2A06, ALL);
        wr(2'd1, 64'd200, ALL);
        cyc(1'b1, 32'd200, 1'b1);
        expect_out("R10", O_LVL, 64'd1);
        clr_sts();
        expect_out("R11", O_LVL, 64'd0);

        // R8: disabled interrupt gives nothing
        wr(2'd0, 64'h2A02, ALL);
        wr(2'd1, 64'd300, ALL);
        cyc(1'b1, 32'd300, 1'b1);
        expect_out("R8", O_LVL, 64'd0);
        expect_out("R8", O_PULSE, 64'd0);

        // R11: pin change drops level
        wr(2'd0, 64'h2A06, ALL);
        wr(2'd1, 64'd310, ALL);
        cyc(1'b1, 32'd310, 1'b1);
        expect_out("R11", O_LVL, 64'd1);
        wr(2'd0, 64'h2C06, ALL);
        expect_out("R11", O_LVL, 64'd0);
        expect_out("R11", O_PIN, 64'd22);

        // R11: switch to edge drops level
        wr(2'd1, 64'd320, ALL);
        cyc(1'b1, 32'd320, 1'b1);
        expect_out("R11", O_LVL, 64'd1);
        wr(2'd0, 64'h2C04, ALL);
        expect_out("R11", O_LVL, 64'd0);

        // R9 message mode
        wr(2'd2, 64'hFEE0_1000_0000_00AB, ALL);
        wr(2'd0, 64'h4004, ALL);
        expect_out("R9", O_PIN, 64'd0);
        wr(2'd1, 64'd400, ALL);
        cyc(1'b1, 32'd400, 1'b1);
        expect_out("R9", O_MSG, 64'd1);
        expect_out("R9", O_MADDR, 64'hFEE0_1000);
        expect_out("R9", O_MDATA, 64'hAB);
        expect_out("R9", O_PULSE, 64'd0);
        cyc(1'b0, 32'd400, 1'b1);
        expect_out("R9", O_MSG, 64'd0);

        // R4 / R7: periodic with value-set, caught up past count 400
        wr(2'd0, 64'h2A4C, ALL);
        wr(2'd1, 64'd50, ALL);
        expect_out("R4", O_PER, 64'd50);
        expect_out("R7", O_CMP, 64'd450);
        expect_out("R4", O_CFG, HI | 64'hAA1C);
        wr(2'd1, 64'd60, ALL);
        expect_out("R4", O_PER, 64'd60);
        expect_out("R4", O_CMP, 64'd450);

        // R6 periodic reload
        cyc(1'b1, 32'd450, 1'b1);
        expect_out("R6", O_PULSE, 64'd1);
        expect_out("R6", O_CMP, 64'd510);

        // R7 catch-up on restart: 510 + (190/60 + 1)*60 = 750
        cyc(1'b0, 32'd450, 1'b0);
        expect_out("R12", O_PULSE, 64'd0);
        cyc(1'b0, 32'd700, 1'b1);
        expect_out("R7", O_CMP, 64'd750);

        // R5 leaving periodic, R12 delivery on stop
        wr(2'd0, 64'h2A04, ALL);
        cyc(1'b0, 32'd700, 1'b1);
        expect_out("R5", O_PER, 64'd0);
        wr(2'd1, 64'd800, ALL);
        cyc(1'b0, 32'd805, 1'b1);
        expect_out("R12", O_PULSE, 64'd0);
        cyc(1'b0, 32'd805, 1'b0);
        expect_out("R12", O_PULSE, 64'd1);
        cyc(1'b0, 32'd805, 1'b0);

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule